// File: doc/BRIEF.md
# Cyclic Transmit Buffer Repeater

This block is a serial transmitter that loops a small byte buffer onto one data line without end. A host fills the buffer with 1 to 32 bytes through a byte write port, then writes a command byte. Once a valid start command is seen, the buffer is shifted out byte after byte, least-significant bit first, one bit for each pulse of a bit-rate enable. After the last bit of the last loaded byte, the first bit of the first byte follows at once.

The stream is fully transparent. No flags, zero insertion or check sequence are added. Cycling stops only on a transmit-reset command. That command empties the buffer, clears the write error flag and returns the line to a constant high level. Writes that arrive while the block is cycling, or while the buffer is full, are dropped and raise a sticky error flag.

Top module: `cyc_tx_repeater`

## Requirements
- R1: Each accepted write stores `wr_data_i` at the next free slot and increments `fill_o`, up to a maximum of 32. A write to a full buffer is dropped, leaves `fill_o` at 32 and sets `wr_err_o`.
- R2: A command with bit 5 (repeat) and bit 3 (transmit) set starts cycling when `fill_o` is non-zero. Bit 1 (message end) is optional, so both 0x2A and 0x28 start. In the cycle after the command, `busy_o` is 1 and `txd_o` shows bit 0 of the first byte.
- R3: Bits leave least-significant first. The output advances by exactly one bit on each clock where `bit_en_i` is 1, and it holds while `bit_en_i` is 0.
- R4: After bit 7 of the last loaded byte, the next bit is bit 0 of byte 0 with no gap. The loop repeats indefinitely.
- R5: A command with bit 0 (transmit reset) set drives `busy_o` to 0, `txd_o` to 1, `fill_o` to 0 and `wr_err_o` to 0 in the next cycle. It wins over start bits carried in the same byte (0x2B).
- R6: Nothing is inserted into the stream. A buffer of all-ones bytes produces only ones on `txd_o`, with no zero after any run of ones.
- R7: A start command given while the buffer is empty is ignored. `busy_o` stays 0 and `txd_o` stays 1.
- R8: A write while `busy_o` is 1 is rejected. `fill_o` is unchanged, `wr_err_o` is set and stays set until a transmit-reset command, and the stream continues undisturbed.
- R9: A command lacking either the repeat or the transmit bit, or carrying any of bits 7, 6, 4 or 2, has no effect.
- R10: After `rst_ni` is asserted, `txd_o` is 1, `busy_o` is 0, `fill_o` is 0 and `wr_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 8 | Byte to append to the buffer |
| cmd_en_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command byte: bit 0 reset, bit 1 end, bit 3 transmit, bit 5 repeat |
| bit_en_i | input | 1 | Bit-rate enable, one pulse per serial bit |
| txd_o | output | 1 | Serial data out, high when idle |
| busy_o | output | 1 | Cycling active |
| fill_o | output | 6 | Number of loaded bytes |
| wr_err_o | output | 1 | Sticky rejected-write flag |

## Verification
Assertions check the following on every cycle:
- the fill bound;
- the hold of the bit position when no enable arrives;
- the return to byte 0 after the last bit;
- the idle state that follows a reset command;
- the locking out of writes while cycling;
- the refusal of start commands that are empty or malformed.

Only the bench scenarios can show that the serial stream matches the loaded bytes bit for bit across several loops, for one-byte, three-byte and full buffers, with no insertions. The scenarios also show that a rejected write leaves the stream unchanged and that the error flag lasts until the next reset command.

// File: rtl/cyc_tx_pkg.sv
package cyc_tx_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned CMD_RST  = 0;
  localparam int unsigned CMD_END  = 1;
  localparam int unsigned CMD_XMIT = 3;
  localparam int unsigned CMD_REP  = 5;
  localparam logic [CMD_W-1:0] CMD_KNOWN =
    CMD_W'((1 << CMD_RST) | (1 << CMD_END) | (1 << CMD_XMIT) | (1 << CMD_REP));

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CYCLE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cyc_tx_buffer.sv
module cyc_tx_buffer #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              lock_i,
  input  logic              clr_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              err_o
);
  logic [FILL_W-1:0]         fill_q;
  logic                      err_q;
  logic                      full_w;
  logic                      wr_ok_w;
  logic [DEPTH-1:0][DW-1:0]  rows_w;

  assign full_w  = (fill_q == FILL_W'(DEPTH));
  assign wr_ok_w = wr_en_i && !lock_i && !clr_i && !full_w;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [DW-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   row_q <= '0;
      else if (wr_ok_w && fill_q == FILL_W'(i))     row_q <= wr_data_i;
    end
    assign rows_w[i] = row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      err_q  <= 1'b0;
    end else if (clr_i) begin
      fill_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok_w) fill_q <= fill_q + FILL_W'(1);
      if (wr_en_i && (lock_i || full_w)) err_q <= 1'b1;
    end
  end

  assign rd_data_o = rows_w[rd_ptr_i];
  assign fill_o    = fill_q;
  assign err_o     = err_q;

  a_r1_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(DEPTH));

  a_r8_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && wr_en_i && !clr_i) |=> ($stable(fill_q) && err_q));

  a_r1_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_w && wr_en_i && !clr_i) |=> (fill_q == FILL_W'(DEPTH) && err_q));
endmodule

// File: rtl/cyc_tx_seq.sv
module cyc_tx_seq
  import cyc_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned BIT_W  = $clog2(DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic              bit_en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic              busy_o,
  output logic              txd_o
);
  seq_state_e       state_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [BIT_W-1:0] bit_idx_q;
  logic             last_bit_w;
  logic             last_byte_w;

  assign last_bit_w  = (bit_idx_q == BIT_W'(DW - 1));
  assign last_byte_w = ((FILL_W'(rd_ptr_q) + FILL_W'(1)) == fill_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_ptr_q  <= '0;
      bit_idx_q <= '0;
    end else if (clr_i) begin
      state_q   <= ST_IDLE;
      rd_ptr_q  <= '0;
      bit_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && fill_i != '0) begin
            state_q   <= ST_CYCLE;
            rd_ptr_q  <= '0;
            bit_idx_q <= '0;
          end
        end
        ST_CYCLE: begin
          if (bit_en_i) begin
            if (last_bit_w) begin
              bit_idx_q <= '0;
              rd_ptr_q  <= last_byte_w ? '0 : rd_ptr_q + PTR_W'(1);
            end else begin
              bit_idx_q <= bit_idx_q + BIT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_ptr_o = rd_ptr_q;
  assign busy_o   = (state_q == ST_CYCLE);
  assign txd_o    = busy_o ? rd_data_i[bit_idx_q] : 1'b1;

  a_r2_start_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i && !busy_o && fill_i != '0) |=>
      (busy_o && rd_ptr_q == '0 && bit_idx_q == '0));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_en_i && !clr_i) |=> ($stable(bit_idx_q) && $stable(rd_ptr_q)));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bit_en_i && !clr_i && last_bit_w && last_byte_w) |=>
      (busy_o && rd_ptr_q == '0 && bit_idx_q == '0));
endmodule

// File: rtl/cyc_tx_repeater.sv
module cyc_tx_repeater
  import cyc_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              cmd_en_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              bit_en_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              wr_err_o
);
  logic             cmd_ok_w;
  logic             clr_w;
  logic             start_w;
  logic [PTR_W-1:0] rd_ptr_w;
  logic [DW-1:0]    rd_data_w;

  // unassigned command bits void the whole command
  assign cmd_ok_w = cmd_en_i && ((cmd_i & ~CMD_KNOWN) == '0);
  assign clr_w    = cmd_ok_w && cmd_i[CMD_RST];
  assign start_w  = cmd_ok_w && !cmd_i[CMD_RST] && cmd_i[CMD_REP] && cmd_i[CMD_XMIT];

  cyc_tx_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .lock_i    (busy_o),
    .clr_i     (clr_w),
    .rd_ptr_i  (rd_ptr_w),
    .rd_data_o (rd_data_w),
    .fill_o    (fill_o),
    .err_o     (wr_err_o)
  );

  cyc_tx_seq #(.DEPTH(DEPTH), .DW(DW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .clr_i     (clr_w),
    .bit_en_i  (bit_en_i),
    .fill_i    (fill_o),
    .rd_data_i (rd_data_w),
    .rd_ptr_o  (rd_ptr_w),
    .busy_o    (busy_o),
    .txd_o     (txd_o)
  );

  a_r5_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i && cmd_i[CMD_RST] && (cmd_i & ~CMD_KNOWN) == '0) |=>
      (!busy_o && txd_o && fill_o == '0 && !wr_err_o));

  a_r7_empty_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i && fill_o == '0 && !busy_o) |=> !busy_o);

  a_r9_bad_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i && !busy_o && ((cmd_i & ~CMD_KNOWN) != '0 || !cmd_i[CMD_REP] || !cmd_i[CMD_XMIT]))
      |=> !busy_o);

  a_r10_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
endmodule

// File: tb/cyc_tx_repeater_tb_top.sv
module cyc_tx_repeater_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_en = 1'b0;
  logic [7:0] cmd = '0;
  logic       bit_en = 1'b0;
  logic       txd;
  logic       busy;
  logic [5:0] fill;
  logic       wr_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [32];
  int mdl_n = 0;
  int pos = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cyc_tx_repeater dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cmd_en_i(cmd_en), .cmd_i(cmd), .bit_en_i(bit_en),
    .txd_o(txd), .busy_o(busy), .fill_o(fill), .wr_err_o(wr_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bit(int k);
    return int'(mdl[(k / 8) % mdl_n][k % 8]);
  endfunction

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic send_cmd(logic [7:0] c);
    @(negedge clk); cmd_en = 1'b1; cmd = c;
    @(negedge clk); cmd_en = 1'b0;
  endtask

  task automatic load(int n, int seed);
    mdl_n = n;
    for (int i = 0; i < n; i++) begin
      mdl[i] = 8'((i * 37 + seed) & 8'hFF);
      wr(mdl[i]);
    end
  endtask

  // checks nbits starting at pos; gap idle cycles before each enable
  task automatic stream(string req, int nbits, int gap);
    for (int k = 0; k < nbits; k++) begin
      chk(req, "txd bit", int'(txd), exp_bit(pos));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(req, "txd hold", int'(txd), exp_bit(pos));
      end
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      pos++;
    end
  endtask

  task automatic t_reset_state();
    chk("R10", "txd", int'(txd), 1);
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "fill", int'(fill), 0);
    chk("R10", "err", int'(wr_err), 0);
  endtask

  task automatic t_fill_full();
    load(32, 5);
    chk("R1", "fill at 32", int'(fill), 32);
    chk("R1", "err before overflow", int'(wr_err), 0);
    wr(8'h55);
    chk("R1", "fill after overflow", int'(fill), 32);
    chk("R1", "err after overflow", int'(wr_err), 1);
    send_cmd(8'h01);
    chk("R5", "fill cleared", int'(fill), 0);
    chk("R5", "err cleared", int'(wr_err), 0);
  endtask

  task automatic t_empty_start();
    send_cmd(8'h2A);
    chk("R7", "busy", int'(busy), 0);
    chk("R7", "txd", int'(txd), 1);
  endtask

  task automatic t_bad_cmds();
    load(3, 1);
    send_cmd(8'h08); chk("R9", "busy xmit only", int'(busy), 0);
    send_cmd(8'h20); chk("R9", "busy repeat only", int'(busy), 0);
    send_cmd(8'h6A); chk("R9", "busy extra bit", int'(busy), 0);
    chk("R9", "fill kept", int'(fill), 3);
    chk("R9", "txd idle", int'(txd), 1);
  endtask

  task automatic t_stream3();
    mdl[0] = 8'hA5; mdl[1] = 8'h0F; mdl[2] = 8'h81; mdl_n = 3;
    send_cmd(8'h01);
    for (int i = 0; i < 3; i++) wr(mdl[i]);
    send_cmd(8'h2A);
    chk("R2", "busy after start", int'(busy), 1);
    pos = 0;
    stream("R4", 72, 0);
    stream("R3", 20, 2);
  endtask

  task automatic t_write_busy();
    wr(8'h33);
    chk("R8", "fill unchanged", int'(fill), 3);
    chk("R8", "err set", int'(wr_err), 1);
    chk("R8", "busy kept", int'(busy), 1);
    stream("R8", 30, 0);
    chk("R8", "err sticky", int'(wr_err), 1);
  endtask

  task automatic t_reset_mid();
    send_cmd(8'h01);
    bit_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      chk("R5", "txd idle", int'(txd), 1);
      @(negedge clk);
    end
    bit_en = 1'b0;
    chk("R5", "busy", int'(busy), 0);
    chk("R5", "fill", int'(fill), 0);
    chk("R5", "err", int'(wr_err), 0);
  endtask

  task automatic t_one_byte();
    mdl[0] = 8'h6E; mdl_n = 1;
    wr(mdl[0]);
    send_cmd(8'h28);
    chk("R2", "busy with 0x28", int'(busy), 1);
    pos = 0;
    stream("R4", 40, 0);
    send_cmd(8'h01);
  endtask

  task automatic t_all_ones();
    mdl[0] = 8'hFF; mdl[1] = 8'hFF; mdl_n = 2;
    wr(8'hFF); wr(8'hFF);
    send_cmd(8'h2A);
    pos = 0;
    stream("R6", 48, 0);
    send_cmd(8'h01);
  endtask

  task automatic t_full_loop();
    load(32, 9);
    send_cmd(8'h2A);
    pos = 0;
    stream("R4", 280, 0);
  endtask

  task automatic t_reset_wins();
    send_cmd(8'h01);
    load(2, 3);
    send_cmd(8'h2B);
    chk("R5", "busy after 0x2B", int'(busy), 0);
    chk("R5", "fill after 0x2B", int'(fill), 0);
    chk("R5", "txd after 0x2B", int'(txd), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fill_full();
    t_empty_start();
    t_bad_cmds();
    t_stream3();
    t_write_busy();
    t_reset_mid();
    t_one_byte();
    t_all_ones();
    t_full_loop();
    t_reset_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule